// File: doc/BRIEF.md
# Prioritized Interrupt and Trap Entry Unit

This block sits in front of instruction issue. In every cycle where an instruction is about to issue, it decides whether control must leave the normal flow. It takes a trap for a synchronous exception. It also takes one for an interrupt that is both pending and unmasked while the global interrupt enable is on. When several interrupts compete, the lowest-numbered one wins.

When a trap is taken, the block performs the whole trap-entry update at once. It produces the cause value and the exception pc, which is the pc of the instruction that has not yet run. It also produces the redirect target, taken from the exception vector, and the new status bits:
- supervisor mode is set;
- the global enable is cleared;
- the previous-mode and previous-enable bits capture the old supervisor and enable values.

The cause marks interrupts with a flag bit. That bit is bit 63 in 64-bit mode and bit 31 otherwise.

All results are registered. A trap decided from the inputs sampled at one rising edge appears on the outputs after that edge, together with a one-cycle strobe. Between traps, every architectural output keeps its last value.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset, `trap_o` is 0; `cause_o`, `epc_o` and `npc_o` are zero; `sup_o` is 1; `gie_o`, `psup_o` and `pgie_o` are 0.
- R2: The candidate set is `irq_pend_i & irq_mask_i` (bit k is interrupt k). With `exc_i` low, no trap is taken when this set is zero or when `gie_i` is 0.
- R3: With `exc_i` low, `gie_i` 1 and a non-zero candidate set, the interrupt taken is the lowest set bit index of the candidate set.
- R4: For an interrupt trap, `cause_o` equals the interrupt index in its low bits plus exactly one flag bit. The flag is at bit 63 when `wide_i` was 1, and at bit 31 when `wide_i` was 0. All other bits are zero.
- R5: On any trap, `epc_o` equals the `pc_i` sampled in the deciding cycle, and `npc_o` equals the `evec_i` sampled in that cycle.
- R6: On any trap, `sup_o` becomes 1, `gie_o` becomes 0, `psup_o` becomes the sampled `sup_i`, and `pgie_o` becomes the sampled `gie_i`.
- R7: When `exc_i` is 1 in an issuing cycle, a trap is taken whatever the interrupt inputs and `gie_i` are. `cause_o` then equals `exc_cause_i` unchanged, and any coincident interrupt is left untaken.
- R8: `trap_o` is high for exactly the one cycle after each issuing cycle that takes a trap. Cause, epc, redirect pc and status update in that same cycle. With no trap, they all hold their previous values.
- R9: When `issue_i` is 0, no trap is taken, even with `exc_i` or enabled interrupts present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | An instruction is about to issue this cycle |
| pc_i | input | XLEN | pc of the instruction about to issue |
| evec_i | input | XLEN | Exception vector address |
| irq_pend_i | input | NIRQ | Pending interrupt bits |
| irq_mask_i | input | NIRQ | Interrupt mask bits |
| gie_i | input | 1 | Current global interrupt enable |
| sup_i | input | 1 | Current supervisor mode bit |
| wide_i | input | 1 | 64-bit mode bit, selects the cause flag position |
| exc_i | input | 1 | Synchronous exception request |
| exc_cause_i | input | XLEN | Cause value of the synchronous exception |
| trap_o | output | 1 | One-cycle trap-taken strobe |
| cause_o | output | XLEN | Cause register |
| epc_o | output | XLEN | Saved exception pc |
| npc_o | output | XLEN | Redirect pc |
| sup_o | output | 1 | Updated supervisor bit |
| gie_o | output | 1 | Updated global enable |
| psup_o | output | 1 | Previous supervisor bit |
| pgie_o | output | 1 | Previous global enable |

## Verification
The assertions check several rules on every cycle:
- no trap without a qualifying cause, and none while issue is low;
- the taken interrupt is the lowest candidate;
- the flag bit sits where the mode bit demands;
- epc, redirect pc and the stacked status follow the deciding cycle's inputs;
- all outputs hold steady between traps.

Only the bench sweeps show that the full cause value is exact across pending/mask combinations in both modes. They also show that an exception leaves a coincident interrupt untaken, and that the held values after a long run of non-trapping cycles are the ones from the last trap.

// File: rtl/trap_entry_unit.sv
module trap_entry_unit #(
  parameter int XLEN        = 64,
  parameter int NIRQ        = 8,
  parameter int NARROW_FLAG = 31
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            issue_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] evec_i,
  input  logic [NIRQ-1:0] irq_pend_i,
  input  logic [NIRQ-1:0] irq_mask_i,
  input  logic            gie_i,
  input  logic            sup_i,
  input  logic            wide_i,
  input  logic            exc_i,
  input  logic [XLEN-1:0] exc_cause_i,
  output logic            trap_o,
  output logic [XLEN-1:0] cause_o,
  output logic [XLEN-1:0] epc_o,
  output logic [XLEN-1:0] npc_o,
  output logic            sup_o,
  output logic            gie_o,
  output logic            psup_o,
  output logic            pgie_o
);

  localparam int IDXW = (NIRQ > 1) ? $clog2(NIRQ) : 1;

  logic [NIRQ-1:0] cand;
  logic            irq_hit;
  logic [IDXW-1:0] irq_idx;
  logic [XLEN-1:0] flag_bit;
  logic [XLEN-1:0] irq_cause;
  logic            take;

  assign cand    = irq_pend_i & irq_mask_i;
  assign irq_hit = gie_i && (cand != '0);

  always_comb begin
    irq_idx = '0;
    for (int k = NIRQ - 1; k >= 0; k--)
      if (cand[k]) irq_idx = IDXW'(k);
  end

  assign flag_bit  = wide_i ? (XLEN'(1) << (XLEN - 1)) : (XLEN'(1) << NARROW_FLAG);
  assign irq_cause = flag_bit | XLEN'(irq_idx);
  assign take      = issue_i && (exc_i || irq_hit);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      trap_o  <= 1'b0;
      cause_o <= '0;
      epc_o   <= '0;
      npc_o   <= '0;
      sup_o   <= 1'b1;
      gie_o   <= 1'b0;
      psup_o  <= 1'b0;
      pgie_o  <= 1'b0;
    end else begin
      trap_o <= take;
      if (take) begin
        cause_o <= exc_i ? exc_cause_i : irq_cause;
        epc_o   <= pc_i;
        npc_o   <= evec_i;
        psup_o  <= sup_i;
        pgie_o  <= gie_i;
        sup_o   <= 1'b1;
        gie_o   <= 1'b0;
      end
    end
  end

  logic [NIRQ-1:0] sel_w, below_w;
  assign sel_w   = NIRQ'(1) << cause_o[IDXW-1:0];
  assign below_w = sel_w - NIRQ'(1);

  AST_NO_SPURIOUS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && !exc_i && (!gie_i || (irq_pend_i & irq_mask_i) == '0)) |=> !trap_o); // R2
  AST_LOWEST_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && !$past(exc_i)) |->
      ((($past(irq_pend_i & irq_mask_i) & below_w) == '0) &&
       (($past(irq_pend_i & irq_mask_i) & sel_w) != '0))); // R3
  AST_FLAG_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && !$past(exc_i)) |->
      (cause_o[XLEN-1] == $past(wide_i) && cause_o[NARROW_FLAG] == !$past(wide_i))); // R4
  AST_EPC_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (epc_o == $past(pc_i) && npc_o == $past(evec_i))); // R5
  AST_STACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (sup_o && !gie_o && psup_o == $past(sup_i) && pgie_o == $past(gie_i))); // R6
  AST_EXC_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && exc_i) |=> (trap_o && cause_o == $past(exc_cause_i))); // R7
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_o |-> ($stable(cause_o) && $stable(epc_o) && $stable(npc_o) &&
                 $stable({sup_o, gie_o, psup_o, pgie_o}))); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_i |=> !trap_o); // R9

endmodule

// File: tb/tb_trap_entry_unit.sv
`timescale 1ns/1ps
module tb_trap_entry_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [63:0] pc = '0, evec = '0, ecause = '0;
  logic [7:0]  pend = '0, mask = '0;
  logic        gie = 1'b0, sup = 1'b0, wide = 1'b0, exc = 1'b0;
  logic        trap;
  logic [63:0] cause, epc, npc;
  logic        sup_q, gie_q, psup_q, pgie_q;

  int vecs = 0;
  int errs = 0;
  logic        e_trap = 1'b0;
  logic [63:0] e_cause = '0, e_epc = '0, e_npc = '0;
  logic [3:0]  e_st = 4'b1000;

  always #2.5 clk = ~clk;

  trap_entry_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .pc_i(pc), .evec_i(evec),
    .irq_pend_i(pend), .irq_mask_i(mask), .gie_i(gie), .sup_i(sup), .wide_i(wide),
    .exc_i(exc), .exc_cause_i(ecause),
    .trap_o(trap), .cause_o(cause), .epc_o(epc), .npc_o(npc),
    .sup_o(sup_q), .gie_o(gie_q), .psup_o(psup_q), .pgie_o(pgie_q));

  task automatic check(input string tag);
    vecs++;
    if (trap !== e_trap || cause !== e_cause || epc !== e_epc || npc !== e_npc ||
        {sup_q, gie_q, psup_q, pgie_q} !== e_st) begin
      errs++;
      $display("FAIL %s: trap=%0b/%0b cause=%h/%h epc=%h/%h npc=%h/%h st=%b/%b",
               tag, trap, e_trap, cause, e_cause, epc, e_epc, npc, e_npc,
               {sup_q, gie_q, psup_q, pgie_q}, e_st);
    end
  endtask

  task automatic apply(input logic iss, input logic [7:0] p, input logic [7:0] m,
                       input logic g, input logic s, input logic w, input logic x,
                       input logic [63:0] xc, input logic [63:0] a, input logic [63:0] v);
    logic [7:0] c;
    int idx;
    logic take;
    string tag;
    @(negedge clk);
    issue = iss; pend = p; mask = m; gie = g; sup = s; wide = w;
    exc = x; ecause = xc; pc = a; evec = v;
    c = p & m;
    idx = -1;
    for (int k = 7; k >= 0; k--) if (c[k]) idx = k;
    take = iss && (x || (g && idx >= 0));
    if (!iss) tag = "R9";
    else if (x) tag = "R7";
    else if (take) tag = "R3";
    else tag = "R2";
    e_trap = take;                                   // R8
    if (take) begin
      if (x) e_cause = xc;
      else e_cause = (w ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000)
                     + 64'(idx);                     // R4
      e_epc = a; e_npc = v;                          // R5
      e_st = {1'b1, 1'b0, s, g};                     // R6
    end
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    errs++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [7:0] masks [8] = '{8'hFF, 8'h00, 8'h01, 8'h80, 8'h0F, 8'hF0, 8'h55, 8'hAA};
    int n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1");
    for (int g = 0; g < 2; g++)
      for (int p = 0; p < 256; p++)
        for (int mi = 0; mi < 8; mi++) begin
          n++;
          apply(1'b1, 8'(p), masks[mi], g[0], p[1], p[0] ^ mi[0], 1'b0, '0,
                64'h1000 + 64'(n) * 4, 64'hFFFF_0000_0000_0100 + 64'(n) * 64'h1_0000);
        end
    for (int i = 0; i < 64; i++)
      apply(1'b1, 8'(i * 37), 8'hFF, i[0], i[1], i[2], 1'b1, 64'(i + 2),
            64'h2000 + 64'(i) * 4, 64'h400 + 64'(i));
    for (int i = 0; i < 32; i++)
      apply(1'b0, 8'hFF, 8'hFF, 1'b1, i[0], i[1], i[2], 64'h5,
            64'h3000 + 64'(i) * 4, 64'h900);
    for (int i = 0; i < 16; i++)
      apply(1'b1, 8'h00, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b0, '0, 64'h4000 + 64'(i), 64'h77);
    apply(1'b1, 8'h80, 8'h80, 1'b1, 1'b0, 1'b1, 1'b0, '0, 64'h5000, 64'h88);
    apply(1'b1, 8'h80, 8'h80, 1'b1, 1'b1, 1'b0, 1'b0, '0, 64'h5004, 64'h8C);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule